// File: doc/BRIEF.md
# Debug Trace Capture Controller

This block records a history of CPU activity into a small on-chip circular buffer during a debug session. A control register chooses which kind of CPU event is recorded, whether the trigger closes or opens the recording window, and whether the session records at all. The block watches three event streams: change-of-flow events with a source address, memory or register accesses with an address and data word, and the program counter of each executed instruction. It keeps the accepted records and offers them on an indexed read port, oldest first.

A debugger writes the control register while the session is disarmed and then raises the arm input. With post-trigger alignment off, the buffer records continuously and overwrites its oldest entries until a trigger freezes it. With alignment on, the buffer stays empty until the trigger and then fills once. A secure input stops any recording and stops the record-enable bit from being set. A valid-count output tells the debugger how many entries the read port can return.

Top module: `trace_capture`

## Requirements
- R1: After reset, `cfg_state` is 0, `fill_cnt` is 0 and `rd_data` is 0.
- R2: `cfg_state` packs the control register as bit 0 = record enable, bit 1 = post-trigger alignment, bits 3:2 = mode. A write through `cfg_we`/`cfg_wdata` takes effect at the next clock edge only when `dbg_arm` is low. Writes made while armed leave `cfg_state` unchanged.
- R3: While `secure` is high, a write can't set the record-enable bit. The other bits of that write still take effect.
- R4: Mode 00 stores only change-of-flow events. Access and program-counter events are ignored.
- R5: Mode 01 stores change-of-flow events, except one whose address equals the address of the entry stored just before it.
- R6: Mode 10 stores every access event, including its address and data. Other events are ignored.
- R7: Mode 11 stores every executed program counter. Other events are ignored.
- R8: With alignment 0, the buffer records from arming and overwrites its oldest entries once 64 are held. The event in the trigger cycle is stored, and after that nothing more is stored until the next arming. `fill_cnt` stops at 64.
- R9: With alignment 1, nothing is stored before the trigger. Recording starts with the event in the trigger cycle and stops once 64 entries are held.
- R10: `rd_data` shows the entry at index `rd_idx` one clock edge after the index is presented. Index 0 is the oldest entry. `rd_data` is 0 when the record-enable bit is clear or `rd_idx` is not below `fill_cnt`. The entry layout is {kind[1:0], addr[15:0], data[15:0]}, where kind is 01 for change of flow, 10 for access and 11 for program counter. The data field is 0 unless kind is 10.
- R11: Nothing is stored while `secure` is high, and nothing is stored in a session armed with the record-enable bit clear.
- R12: The first clock edge with `dbg_arm` high after it was low sets `fill_cnt` to 0. Disarming keeps the buffer contents readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control register write value |
| cfg_state | output | 4 | Current control register value |
| dbg_arm | input | 1 | Session armed while high |
| secure | input | 1 | Secure mode; blocks recording |
| trig | input | 1 | Trigger pulse |
| cof_vld | input | 1 | Change-of-flow event valid |
| cof_addr | input | 16 | Change-of-flow source address |
| acc_vld | input | 1 | Access event valid |
| acc_addr | input | 16 | Access address |
| acc_data | input | 16 | Access data |
| pc_vld | input | 1 | Executed-instruction event valid |
| pc_addr | input | 16 | Executed program counter |
| rd_idx | input | 6 | Read index, 0 = oldest |
| rd_data | output | 34 | Entry read out |
| fill_cnt | output | 7 | Number of readable entries |

## Verification
A control write shows on `cfg_state` one edge after the strobe. An event that is accepted is counted in `fill_cnt` at the same edge that samples it. Arming clears the count at its first edge. A read returns data one edge after the index is presented. The bench drives every input just after a falling edge and samples just before the next falling edge, so each check falls exactly one rising edge after its stimulus. The scoreboard queues the expected entries while driving and then pops them as it walks the read index.

// File: rtl/trc_pkg.sv
package trc_pkg;
   typedef enum logic [1:0] {
      TM_FLOW   = 2'b00,
      TM_NOREP  = 2'b01,
      TM_ACCESS = 2'b10,
      TM_PCSTEP = 2'b11
   } tmode_e;

   typedef enum logic [1:0] {
      EK_NONE   = 2'b00,
      EK_FLOW   = 2'b01,
      EK_ACCESS = 2'b10,
      EK_PC     = 2'b11
   } ekind_e;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_PRE  = 3'd1,
      SQ_WAIT = 3'd2,
      SQ_POST = 3'd3,
      SQ_DONE = 3'd4
   } sq_e;
endpackage

// File: rtl/trc_cfg.sv
module trc_cfg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [3:0] wdata,
   input  logic       armed,
   input  logic       secure,
   output logic [3:0] state
);
   logic [3:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we && !armed) begin
         q <= {wdata[3:1], wdata[0] & ~secure};
      end
   end

   assign state = q;
endmodule

// File: rtl/trc_filter.sv
module trc_filter #(
   parameter int AW = 16,
   parameter int DW = 16,
   localparam int EW = 2 + AW + DW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  trc_pkg::tmode_e     mode,
   input  logic                clear,
   input  logic                commit,
   input  logic                cof_vld,
   input  logic [AW-1:0]       cof_addr,
   input  logic                acc_vld,
   input  logic [AW-1:0]       acc_addr,
   input  logic [DW-1:0]       acc_data,
   input  logic                pc_vld,
   input  logic [AW-1:0]       pc_addr,
   output logic                cand_vld,
   output logic [EW-1:0]       cand_entry
);
   import trc_pkg::*;

   logic          last_vld;
   logic [AW-1:0] last_addr;
   logic          repeat_hit;

   assign repeat_hit = last_vld && (last_addr == cof_addr);

   always_comb begin
      cand_vld   = 1'b0;
      cand_entry = '0;
      unique case (mode)
         TM_FLOW: begin
            cand_vld   = cof_vld;
            cand_entry = {EK_FLOW, cof_addr, {DW{1'b0}}};
         end
         TM_NOREP: begin
            cand_vld   = cof_vld && !repeat_hit;
            cand_entry = {EK_FLOW, cof_addr, {DW{1'b0}}};
         end
         TM_ACCESS: begin
            cand_vld   = acc_vld;
            cand_entry = {EK_ACCESS, acc_addr, acc_data};
         end
         TM_PCSTEP: begin
            cand_vld   = pc_vld;
            cand_entry = {EK_PC, pc_addr, {DW{1'b0}}};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         last_vld  <= 1'b0;
         last_addr <= '0;
      end else if (commit) begin
         last_vld  <= 1'b1;
         last_addr <= cand_entry[DW +: AW];
      end
   end
endmodule

// File: rtl/trc_seq.sv
module trc_seq #(
   parameter int DEPTH = 64,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          armed,
   input  logic          src_en,
   input  logic          align,
   input  logic          secure,
   input  logic          trig,
   input  logic          cand_vld,
   input  logic [CW-1:0] count,
   output logic          clear,
   output logic          commit,
   output trc_pkg::sq_e  st
);
   import trc_pkg::*;

   logic arm_q;
   logic arm_rise;
   logic window;
   logic last_slot;
   sq_e  nxt;

   assign arm_rise  = armed && !arm_q;
   assign clear     = arm_rise;
   assign window    = (st == SQ_PRE) || (st == SQ_POST) || (st == SQ_WAIT && trig);
   assign commit    = cand_vld && window && armed && !arm_rise && !secure;
   assign last_slot = (count == CW'(DEPTH - 1));

   always_comb begin
      nxt = st;
      if (!armed) begin
         nxt = SQ_IDLE;
      end else if (arm_rise) begin
         if (src_en && !secure) nxt = align ? SQ_WAIT : SQ_PRE;
         else                   nxt = SQ_IDLE;
      end else begin
         unique case (st)
            SQ_PRE:  if (trig) nxt = SQ_DONE;
            SQ_WAIT: if (trig) nxt = (commit && last_slot) ? SQ_DONE : SQ_POST;
            SQ_POST: if (commit && last_slot) nxt = SQ_DONE;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         st    <= SQ_IDLE;
      end else begin
         arm_q <= armed;
         st    <= nxt;
      end
   end
endmodule

// File: rtl/trc_buf.sv
module trc_buf #(
   parameter int EW     = 34,
   parameter int DEPTH  = 64,
   parameter bit RD_REG = 1'b1,
   localparam int IW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          we,
   input  logic [EW-1:0] wentry,
   input  logic          src_en,
   input  logic [IW-1:0] rd_idx,
   output logic [EW-1:0] rd_data,
   output logic [CW-1:0] count
);
   logic [EW-1:0] mem [DEPTH];
   logic [IW-1:0] wptr;
   logic [IW-1:0] base;
   logic [IW-1:0] phys;
   logic          rd_ok;
   logic [EW-1:0] rd_val;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         wptr  <= '0;
         count <= '0;
      end else if (we) begin
         wptr <= wptr + 1'b1;
         if (count != CW'(DEPTH)) count <= count + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (we && !clear) mem[wptr] <= wentry;
   end

   assign base   = wptr - count[IW-1:0];
   assign phys   = base + rd_idx;
   assign rd_ok  = src_en && (CW'(rd_idx) < count);
   assign rd_val = rd_ok ? mem[phys] : '0;

   if (RD_REG) begin : g_rd_flop
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_val;
      end
   end else begin : g_rd_wire
      assign rd_data = rd_val;
   end
endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
   parameter int AW     = 16,
   parameter int DW     = 16,
   parameter int DEPTH  = 64,
   parameter bit RD_REG = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [3:0]                  cfg_wdata,
   output logic [3:0]                  cfg_state,
   input  logic                        dbg_arm,
   input  logic                        secure,
   input  logic                        trig,
   input  logic                        cof_vld,
   input  logic [AW-1:0]               cof_addr,
   input  logic                        acc_vld,
   input  logic [AW-1:0]               acc_addr,
   input  logic [DW-1:0]               acc_data,
   input  logic                        pc_vld,
   input  logic [AW-1:0]               pc_addr,
   input  logic [$clog2(DEPTH)-1:0]    rd_idx,
   output logic [2+AW+DW-1:0]          rd_data,
   output logic [$clog2(DEPTH+1)-1:0]  fill_cnt
);
   import trc_pkg::*;

   localparam int EW = 2 + AW + DW;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      initial $error("trace_capture: DEPTH must be a power of two of at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      initial $error("trace_capture: AW and DW must be positive");
   end

   logic          clear;
   logic          commit;
   logic          cand_vld;
   logic [EW-1:0] cand_entry;
   sq_e           seq_st;
   tmode_e        mode;

   assign mode = tmode_e'(cfg_state[3:2]);

   trc_cfg u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .wdata  (cfg_wdata),
      .armed  (dbg_arm),
      .secure (secure),
      .state  (cfg_state)
   );

   trc_filter #(.AW(AW), .DW(DW)) u_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .clear      (clear),
      .commit     (commit),
      .cof_vld    (cof_vld),
      .cof_addr   (cof_addr),
      .acc_vld    (acc_vld),
      .acc_addr   (acc_addr),
      .acc_data   (acc_data),
      .pc_vld     (pc_vld),
      .pc_addr    (pc_addr),
      .cand_vld   (cand_vld),
      .cand_entry (cand_entry)
   );

   trc_seq #(.DEPTH(DEPTH)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (dbg_arm),
      .src_en   (cfg_state[0]),
      .align    (cfg_state[1]),
      .secure   (secure),
      .trig     (trig),
      .cand_vld (cand_vld),
      .count    (fill_cnt),
      .clear    (clear),
      .commit   (commit),
      .st       (seq_st)
   );

   trc_buf #(.EW(EW), .DEPTH(DEPTH), .RD_REG(RD_REG)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .we      (commit),
      .wentry  (cand_entry),
      .src_en  (cfg_state[0]),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .count   (fill_cnt)
   );
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
   parameter int DEPTH  = 64,
   parameter int EW     = 34,
   parameter bit RD_REG = 1'b1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dbg_arm,
   input logic          secure,
   input logic          trig,
   input logic [3:0]    cfg_state,
   input logic [CW-1:0] fill_cnt,
   input logic [EW-1:0] rd_data,
   input trc_pkg::sq_e  seq_st
);
   import trc_pkg::*;

   a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dbg_arm) |-> $stable(cfg_state));

   a_r3_src_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (secure && !cfg_state[0]) |=> !cfg_state[0]);

   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_st == SQ_DONE) |=> $stable(fill_cnt));

   a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CW'(DEPTH));

   a_r9_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_st == SQ_WAIT && !trig) |=> $stable(fill_cnt));

   a_r11_secure_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (secure && dbg_arm && $past(dbg_arm)) |=> $stable(fill_cnt));

   a_r12_arm_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_arm) |=> (fill_cnt == '0));

   if (RD_REG) begin : g_rd_chk
      a_r10_rd_gate: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_state[0] |=> (rd_data == '0));
   end
endmodule

bind trace_capture trace_capture_chk #(
   .DEPTH  (DEPTH),
   .EW     (2 + AW + DW),
   .RD_REG (RD_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dbg_arm   (dbg_arm),
   .secure    (secure),
   .trig      (trig),
   .cfg_state (cfg_state),
   .fill_cnt  (fill_cnt),
   .rd_data   (rd_data),
   .seq_st    (seq_st)
);

// File: tb/sim_trace_capture.sv
module sim_trace_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_wdata = '0;
   logic [3:0]  cfg_state;
   logic        dbg_arm = 1'b0;
   logic        secure = 1'b0;
   logic        trig = 1'b0;
   logic        cof_vld = 1'b0;
   logic [15:0] cof_addr = '0;
   logic        acc_vld = 1'b0;
   logic [15:0] acc_addr = '0;
   logic [15:0] acc_data = '0;
   logic        pc_vld = 1'b0;
   logic [15:0] pc_addr = '0;
   logic [5:0]  rd_idx = '0;
   logic [33:0] rd_data;
   logic [6:0]  fill_cnt;

   int checks = 0;
   int errors = 0;
   logic [33:0] exp_q[$];

   always #10 clk = ~clk;

   trace_capture u0 (.*);

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [3:0] v);
      cfg_wdata = v;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic set_arm(input bit v);
      dbg_arm = v;
      @(negedge clk);
   endtask

   // kind: 0 none, 1 flow, 2 access, 3 program counter
   task automatic drive(input int kind, input logic [15:0] a, input logic [15:0] d,
                        input bit t, input bit keep);
      cof_vld = (kind == 1);
      acc_vld = (kind == 2);
      pc_vld  = (kind == 3);
      cof_addr = a; acc_addr = a; pc_addr = a; acc_data = d;
      trig = t;
      if (keep) exp_q.push_back({2'(kind), a, (kind == 2) ? d : 16'h0});
      @(negedge clk);
      cof_vld = 1'b0; acc_vld = 1'b0; pc_vld = 1'b0; trig = 1'b0;
   endtask

   task automatic monitor_drain(input string req);
      int n = exp_q.size();
      check(fill_cnt == 7'(n), req, 64'(fill_cnt), 64'(n));
      for (int i = 0; i < n; i++) begin
         logic [33:0] e;
         rd_idx = 6'(i);
         @(negedge clk);
         e = exp_q.pop_front();
         check(rd_data === e, req, 64'(rd_data), 64'(e));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cfg_state == 4'h0, "R1", 64'(cfg_state), 0);
      check(fill_cnt == 7'd0, "R1", 64'(fill_cnt), 0);
      check(rd_data == '0, "R1", 64'(rd_data), 0);

      // R4 flow mode, R8 freeze at trigger
      wr_cfg(4'b0001);
      check(cfg_state == 4'b0001, "R2", 64'(cfg_state), 64'h1);
      set_arm(1);
      drive(1, 16'h0100, 16'h0, 0, 1);
      drive(2, 16'h0200, 16'h1234, 0, 0);
      drive(3, 16'h0300, 16'h0, 0, 0);
      drive(1, 16'h0104, 16'h0, 0, 1);
      drive(1, 16'h0108, 16'h0, 1, 1);
      drive(1, 16'h010C, 16'h0, 0, 0);
      check(fill_cnt == 7'd3, "R8", 64'(fill_cnt), 3);
      // R2 write while armed ignored
      wr_cfg(4'b1110);
      check(cfg_state == 4'b0001, "R2", 64'(cfg_state), 64'h1);
      monitor_drain("R4");

      // R5 no-repeat mode
      set_arm(0);
      wr_cfg(4'b0101);
      set_arm(1);
      check(fill_cnt == 7'd0, "R12", 64'(fill_cnt), 0);
      drive(1, 16'h0010, 16'h0, 0, 1);
      drive(1, 16'h0010, 16'h0, 0, 0);
      drive(1, 16'h0020, 16'h0, 0, 1);
      drive(1, 16'h0010, 16'h0, 0, 1);
      drive(0, 16'h0, 16'h0, 1, 0);
      monitor_drain("R5");

      // R6 access mode
      set_arm(0);
      wr_cfg(4'b1001);
      set_arm(1);
      drive(2, 16'h0100, 16'hAAAA, 0, 1);
      drive(1, 16'h0500, 16'h0, 0, 0);
      drive(2, 16'h0102, 16'hBBBB, 1, 1);
      monitor_drain("R6");

      // R7 program counter mode
      set_arm(0);
      wr_cfg(4'b1101);
      set_arm(1);
      drive(3, 16'h0200, 16'h0, 0, 1);
      drive(2, 16'h0900, 16'h5555, 0, 0);
      drive(3, 16'h0202, 16'h0, 1, 1);
      monitor_drain("R7");

      // R8 wrap and saturate
      set_arm(0);
      wr_cfg(4'b0001);
      set_arm(1);
      for (int i = 0; i < 70; i++) drive(1, 16'h2000 + 16'(i), 16'h0, 0, 1);
      while (exp_q.size() > 64) void'(exp_q.pop_front());
      drive(0, 16'h0, 16'h0, 1, 0);
      drive(1, 16'h3000, 16'h0, 0, 0);
      check(fill_cnt == 7'd64, "R8", 64'(fill_cnt), 64);
      monitor_drain("R8");

      // R9 start at trigger, stop when full
      set_arm(0);
      wr_cfg(4'b0011);
      set_arm(1);
      drive(1, 16'h0050, 16'h0, 0, 0);
      check(fill_cnt == 7'd0, "R9", 64'(fill_cnt), 0);
      drive(1, 16'h0060, 16'h0, 1, 1);
      for (int i = 0; i < 70; i++) drive(1, 16'h1000 + 16'(i), 16'h0, 0, (i < 63));
      check(fill_cnt == 7'd64, "R9", 64'(fill_cnt), 64);
      monitor_drain("R9");

      // R3 secure blocks the enable bit; R11 no recording
      set_arm(0);
      secure = 1'b1;
      wr_cfg(4'b1011);
      check(cfg_state == 4'b1010, "R3", 64'(cfg_state), 64'hA);
      set_arm(1);
      drive(3, 16'h0400, 16'h0, 1, 0);
      check(fill_cnt == 7'd0, "R11", 64'(fill_cnt), 0);
      set_arm(0);
      secure = 1'b0;
      wr_cfg(4'b0001);
      set_arm(1);
      drive(1, 16'h0A00, 16'h0, 0, 1);
      secure = 1'b1;
      drive(1, 16'h0B00, 16'h0, 0, 0);
      secure = 1'b0;
      drive(1, 16'h0C00, 16'h0, 1, 1);
      monitor_drain("R11");

      // R10 out-of-range index and disabled read
      rd_idx = 6'd5;
      @(negedge clk);
      check(rd_data == '0, "R10", 64'(rd_data), 0);
      set_arm(0);
      rd_idx = 6'd0;
      @(negedge clk);
      check(rd_data == {2'b01, 16'h0A00, 16'h0}, "R12", 64'(rd_data), 64'h1_0A00_0000);
      wr_cfg(4'b0000);
      @(negedge clk);
      check(rd_data == '0, "R10", 64'(rd_data), 0);

      // R12 re-arming empties the buffer
      wr_cfg(4'b0001);
      check(fill_cnt == 7'd2, "R12", 64'(fill_cnt), 2);
      set_arm(1);
      check(fill_cnt == 7'd0, "R12", 64'(fill_cnt), 0);
      set_arm(0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule